// File: doc/BRIEF.md
# Received Word Acceptance Filter

This block sits behind a serial avionics line receiver. The receiver assembles 32-bit words and raises a one-cycle end-of-sequence strobe once a word is complete. On that strobe the filter replaces the word's last bit with a parity-status flag and runs up to two screening tests, each switched on by its own control input:

- a compare of the two source/destination bits against a programmed pair;
- a lookup of the word's 8-bit label in a small table of wanted labels.

When every enabled test passes, the word is queued in a 32-deep receive FIFO. A word that fails any enabled test is dropped without a trace.

Host logic fills the label table through a simple write port. It drains the FIFO through a pop input, with the oldest word always shown on the head output. A word that passes the filter but finds the FIFO full is lost. That loss raises a sticky overflow flag, which stays set until a dedicated clear input is asserted.

Bits are numbered 1 to 32 as on the wire. Bit n sits at vector index n-1.

Top module: `rxword_gate`

## Requirements
- R1: Nothing is evaluated or queued unless `eos` is high in a cycle. A word that is presented with `eos` low leaves `fill_count` unchanged.
- R2: If the 32 received bits hold an odd number of ones, the stored word equals the received word with bit 32 (index 31) forced to 0.
- R3: If the 32 received bits hold an even number of ones, the stored word has bit 32 set to 1. The word is still queued.
- R4: With `sd_chk_en` low, the values of bits 9 and 10 have no effect on acceptance.
- R5: With `sd_chk_en` high, a word is dropped unless bit 9 (index 8) equals `sd_want[0]` and bit 10 (index 9) equals `sd_want[1]`.
- R6: With `lbl_chk_en` low, the label has no effect on acceptance.
- R7: With `lbl_chk_en` high, a word is dropped unless its label, bits 1 to 8 (index 7:0), equals the label of a table entry that has been written since reset. Unwritten entries never match, including for label 0x00.
- R8: With both checks enabled, a word is queued only if both checks pass.
- R9: When `tbl_we` is high at a clock edge, entry `tbl_addr` takes `tbl_data` and becomes valid. A later write to the same entry replaces the old label, and the old label then no longer matches.
- R10: For an accepted word, `eos` is sampled at edge k, and `fill_count` has risen by one after edge k+1. It is still unchanged after edge k.
- R11: An accepted word that arrives while the FIFO holds 32 entries is discarded and `overflow` goes high. `overflow` stays high until `ovf_clr` is asserted without a new drop in the same cycle.
- R12: `not_empty` is high when `fill_count` is nonzero. `half_full` is high when `fill_count` is 16 or more. `full` is high when `fill_count` is 32. After reset all three flags are low and `fill_count` is 0.
- R13: `head_word` shows the oldest queued word, and `pop` removes it. Words leave in arrival order. A `pop` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eos | input | 1 | Word-complete strobe from the receiver |
| rx_word | input | 32 | Received word, bit 1 at index 0 |
| sd_chk_en | input | 1 | Enables the source/destination compare |
| sd_want | input | 2 | Required values of bits 10 and 9 |
| lbl_chk_en | input | 1 | Enables the label lookup |
| tbl_we | input | 1 | Label table write strobe |
| tbl_addr | input | 4 | Label table entry to write |
| tbl_data | input | 8 | Label value to write |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| pop | input | 1 | Removes the head word from the FIFO |
| head_word | output | 32 | Oldest queued word |
| fill_count | output | 6 | Number of queued words |
| not_empty | output | 1 | FIFO holds at least one word |
| half_full | output | 1 | FIFO holds 16 or more words |
| full | output | 1 | FIFO holds 32 words |
| overflow | output | 1 | Sticky flag for an accepted word that was lost |

## Verification
A wrong table valid bit, compare, or parity flag shows at the ports two edges after the offending strobe. It appears there as a `fill_count` that did or did not step. Its content effect shows only when the word reaches the FIFO head. The scoreboard therefore compares every drained word against a model built from the requirements alone.

A read or write pointer that slips, or a count that drifts, shows as out-of-order or repeated head words during the drain. It also shows as flags that disagree with the model's queue depth. The full-FIFO and empty-pop corners are driven on purpose so that these faults appear within the run.

// File: rtl/rxword_gate_pkg.sv
package rxword_gate_pkg;
    // Word format: fixed by the line protocol
    localparam int WORD_W  = 32;
    localparam int LBL_W   = 8;
    localparam int SD_LSB  = 8;   // bit 9 on the wire
    localparam int FLAG_IX = 31;  // bit 32 on the wire

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LBL_W-1:0]  label_t;

    typedef struct packed {
        logic  push;
        word_t word;
    } eval_st_t;
endpackage

// File: rtl/rxw_label_table.sv
module rxw_label_table
    import rxword_gate_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int AW = $clog2(N_ENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  label_t        wdata,
    input  label_t        lbl_in,
    output logic          hit
);
    typedef struct packed {
        logic [N_ENT-1:0]            vld;
        logic [N_ENT-1:0][LBL_W-1:0] lbl;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [N_ENT-1:0] hit_vec;

    always_comb begin
        tbl_d = tbl_q;
        if (we) begin
            tbl_d.vld[waddr] = 1'b1;
            tbl_d.lbl[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit_vec[i] = tbl_q.vld[i] && (tbl_q.lbl[i] == lbl_in);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/rxw_word_eval.sv
module rxw_word_eval
    import rxword_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eos,
    input  word_t      rx_word,
    input  logic       sd_chk_en,
    input  logic [1:0] sd_want,
    input  logic       lbl_chk_en,
    input  logic       lbl_hit,
    output logic       push,
    output word_t      push_word
);
    eval_st_t st_d, st_q;
    logic odd_ones, sd_ok, lbl_ok;

    always_comb begin
        odd_ones = ^rx_word;
        sd_ok    = !sd_chk_en || (rx_word[SD_LSB +: 2] == sd_want);
        lbl_ok   = !lbl_chk_en || lbl_hit;
        st_d     = st_q;
        st_d.push = eos && sd_ok && lbl_ok;
        if (eos) begin
            st_d.word          = rx_word;
            st_d.word[FLAG_IX] = ~odd_ones;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push      = st_q.push;
    assign push_word = st_q.word;
endmodule

// File: rtl/rxw_fifo.sv
module rxw_fifo
    import rxword_gate_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  word_t         wdata,
    input  logic          pop,
    input  logic          ovf_clr,
    output word_t         head,
    output logic [CW-1:0] count,
    output logic          not_empty,
    output logic          half_full,
    output logic          full,
    output logic          overflow
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    fifo_st_t st_d, st_q;
    word_t    mem [DEPTH];
    logic     do_push, do_pop, is_full;

    always_comb begin
        is_full = (st_q.cnt == CNT_MAX);
        do_push = push && !is_full;
        do_pop  = pop && (st_q.cnt != '0);
        st_d    = st_q;
        if (do_push) st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + 1'b1;
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
        if (push && is_full) st_d.ovf = 1'b1;
        else if (ovf_clr)    st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end

    assign head      = mem[st_q.rp];
    assign count     = st_q.cnt;
    assign not_empty = (st_q.cnt != '0);
    assign half_full = (st_q.cnt >= CNT_HALF);
    assign full      = is_full;
    assign overflow  = st_q.ovf;
endmodule

// File: rtl/rxword_gate.sv
module rxword_gate
    import rxword_gate_pkg::*;
#(
    parameter int FIFO_D = 32,
    parameter int TBL_N  = 16,
    localparam int CNT_W  = $clog2(FIFO_D + 1),
    localparam int TBL_AW = $clog2(TBL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eos,
    input  logic [31:0]       rx_word,
    input  logic              sd_chk_en,
    input  logic [1:0]        sd_want,
    input  logic              lbl_chk_en,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_addr,
    input  logic [7:0]        tbl_data,
    input  logic              ovf_clr,
    input  logic              pop,
    output logic [31:0]       head_word,
    output logic [CNT_W-1:0]  fill_count,
    output logic              not_empty,
    output logic              half_full,
    output logic              full,
    output logic              overflow
);
    logic  lbl_hit;
    logic  push;
    word_t push_word;

    rxw_label_table #(.N_ENT(TBL_N)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .waddr  (tbl_addr),
        .wdata  (tbl_data),
        .lbl_in (rx_word[LBL_W-1:0]),
        .hit    (lbl_hit)
    );

    rxw_word_eval u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .eos        (eos),
        .rx_word    (rx_word),
        .sd_chk_en  (sd_chk_en),
        .sd_want    (sd_want),
        .lbl_chk_en (lbl_chk_en),
        .lbl_hit    (lbl_hit),
        .push       (push),
        .push_word  (push_word)
    );

    rxw_fifo #(.DEPTH(FIFO_D)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .wdata     (push_word),
        .pop       (pop),
        .ovf_clr   (ovf_clr),
        .head      (head_word),
        .count     (fill_count),
        .not_empty (not_empty),
        .half_full (half_full),
        .full      (full),
        .overflow  (overflow)
    );
endmodule

// File: rtl/rxword_gate_chk.sv
module rxword_gate_chk #(
    parameter int FIFO_D = 32,
    localparam int CNT_W = $clog2(FIFO_D + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eos,
    input logic             pop,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] fill_count,
    input logic             full,
    input logic             overflow
);
    // R1, R10: a rise in occupancy needs a strobe two edges earlier
    p_rise_needs_eos_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count > $past(fill_count)) |-> $past(eos, 2));

    // R13: occupancy moves by at most one per cycle
    p_count_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == $past(fill_count)) || (fill_count == $past(fill_count) + 1'b1)
        || (fill_count == $past(fill_count) - 1'b1));

    // R12: occupancy never exceeds the depth
    p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_count) <= FIFO_D);

    // R11: overflow only rises from a full FIFO
    p_ovf_from_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(full));

    // R11: overflow holds until cleared
    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overflow) && !$past(ovf_clr)) |-> overflow);

    // R13: an empty FIFO cannot drop below zero on pop
    p_empty_pop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_count) == '0 && $past(pop)) |-> (fill_count <= 1));
endmodule

bind rxword_gate rxword_gate_chk #(.FIFO_D(FIFO_D)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eos        (eos),
    .pop        (pop),
    .ovf_clr    (ovf_clr),
    .fill_count (fill_count),
    .full       (full),
    .overflow   (overflow)
);

// File: tb/sim_rxword_gate.sv
module sim_rxword_gate;
    localparam int FD = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eos = 1'b0;
    logic [31:0] rx_word = '0;
    logic        sd_chk_en = 1'b0;
    logic [1:0]  sd_want = 2'b00;
    logic        lbl_chk_en = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [7:0]  tbl_data = '0;
    logic        ovf_clr = 1'b0;
    logic        pop = 1'b0;
    logic [31:0] head_word;
    logic [5:0]  fill_count;
    logic        not_empty, half_full, full, overflow;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] exp_q[$];
    logic [7:0]  m_lbl [16];
    logic        m_vld [16];

    always #2 clk = ~clk;

    rxword_gate u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mkw(input logic [7:0] lbl, input logic [1:0] sd, input logic [21:0] hi);
        return {hi, sd, lbl};
    endfunction

    function automatic bit model_accept(input logic [31:0] w);
        bit sd_ok, lb_ok;
        sd_ok = !sd_chk_en || (w[9:8] == sd_want);
        lb_ok = !lbl_chk_en;
        for (int i = 0; i < 16; i++)
            if (m_vld[i] && m_lbl[i] == w[7:0]) lb_ok = 1'b1;
        return sd_ok && lb_ok;
    endfunction

    // driver: applies one word and records what the queue should hold
    task automatic send(input logic [31:0] w);
        @(negedge clk); rx_word = w; eos = 1'b1;
        @(negedge clk); eos = 1'b0; rx_word = ~w;
        @(negedge clk);
        if (model_accept(w) && exp_q.size() < FD)
            exp_q.push_back({~(^w), w[30:0]});
    endtask

    task automatic tbl_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
        @(negedge clk); tbl_we = 1'b0;
        m_lbl[a] = d; m_vld[a] = 1'b1;
    endtask

    // monitor: drains the FIFO and compares against the scoreboard
    task automatic drain(input string req);
        logic [31:0] e;
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(not_empty == 1'b1, req, {31'd0, not_empty}, 32'd1);
            chk(head_word == e, req, head_word, e);
            pop = 1'b1;
            @(negedge clk); pop = 1'b0;
        end
        chk(fill_count == 6'd0, req, {26'd0, fill_count}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] w;
        for (int i = 0; i < 16; i++) begin m_lbl[i] = '0; m_vld[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(fill_count == 0 && !not_empty && !half_full && !full && !overflow, "R12 reset",
            {26'd0, fill_count}, 32'd0);

        // R1: words without a strobe are ignored
        rx_word = 32'h1234_5678;
        repeat (4) @(negedge clk);
        chk(fill_count == 0, "R1 no eos", {26'd0, fill_count}, 32'd0);

        // R10: push timing
        w = mkw(8'h11, 2'b00, 22'h00_0001);
        @(negedge clk); rx_word = w; eos = 1'b1;
        @(negedge clk); eos = 1'b0;
        chk(fill_count == 0, "R10 one edge", {26'd0, fill_count}, 32'd0);
        @(negedge clk);
        chk(fill_count == 1, "R10 two edges", {26'd0, fill_count}, 32'd1);
        exp_q.push_back({~(^w), w[30:0]});

        // R2, R3: parity flag with both checks off
        send(32'h8000_0000);          // one set bit: odd, stored with bit 32 cleared
        send(32'h8000_0001);          // two set bits: even, bit 32 set
        send(32'h0000_0003);          // even, bit 32 set
        send(32'h0000_0007);          // odd
        chk(fill_count == 5, "R3 even words stored", {26'd0, fill_count}, 32'd5);
        drain("R2 R3 parity flag");

        // R4, R5: source/destination compare
        send(mkw(8'h01, 2'b01, 22'h0_0abc));   // R4: off, accepted
        sd_chk_en = 1'b1; sd_want = 2'b10;
        send(mkw(8'h02, 2'b10, 22'h0_1111));   // match
        send(mkw(8'h03, 2'b01, 22'h0_2222));   // mismatch
        send(mkw(8'h04, 2'b00, 22'h0_3333));   // mismatch
        chk(fill_count == 2, "R5 sd filter", {26'd0, fill_count}, 32'd2);
        drain("R4 R5 sd");
        sd_chk_en = 1'b0;

        // R6, R7, R9: label table
        send(mkw(8'h77, 2'b11, 22'h0_0042));   // R6: off, accepted
        lbl_chk_en = 1'b1;
        send(mkw(8'h00, 2'b00, 22'h0_0001));   // R7: empty table never matches
        chk(fill_count == 1, "R7 empty table", {26'd0, fill_count}, 32'd1);
        tbl_write(4'd3, 8'h31);
        tbl_write(4'd15, 8'hA5);
        send(mkw(8'h31, 2'b00, 22'h1_0000));
        send(mkw(8'hA5, 2'b00, 22'h2_0000));
        send(mkw(8'h32, 2'b00, 22'h3_0000));
        chk(fill_count == 3, "R7 label lookup", {26'd0, fill_count}, 32'd3);
        tbl_write(4'd3, 8'h44);
        send(mkw(8'h31, 2'b00, 22'h0_5555));   // replaced: dropped
        send(mkw(8'h44, 2'b00, 22'h0_6666));
        chk(fill_count == 4, "R9 overwrite", {26'd0, fill_count}, 32'd4);
        drain("R6 R7 R9 label");

        // R8: both checks
        sd_chk_en = 1'b1; sd_want = 2'b01;
        send(mkw(8'hA5, 2'b01, 22'h0_0101));   // both pass
        send(mkw(8'hA5, 2'b10, 22'h0_0202));   // sd fails
        send(mkw(8'h99, 2'b01, 22'h0_0303));   // label fails
        send(mkw(8'h99, 2'b11, 22'h0_0404));   // both fail
        chk(fill_count == 1, "R8 both", {26'd0, fill_count}, 32'd1);
        drain("R8 both");
        sd_chk_en = 1'b0; lbl_chk_en = 1'b0;

        // R11, R12: fill, flags, overflow
        for (int i = 0; i < FD; i++) begin
            send(32'h0100_0000 + i);
            if (i == 14) chk(!half_full, "R12 below half", {31'd0, half_full}, 32'd0);
            if (i == 15) chk(half_full, "R12 half", {31'd0, half_full}, 32'd1);
        end
        chk(full && fill_count == 32 && !overflow, "R12 full", {26'd0, fill_count}, 32'd32);
        send(32'hDEAD_BEEF);
        chk(overflow && fill_count == 32, "R11 drop when full", {31'd0, overflow}, 32'd1);
        repeat (3) @(negedge clk);
        chk(overflow, "R11 sticky", {31'd0, overflow}, 32'd1);
        ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk(!overflow, "R11 clear", {31'd0, overflow}, 32'd0);

        // R13: order on drain, then pop on empty
        drain("R13 order");
        chk(!not_empty && !full && !half_full, "R12 empty flags", {31'd0, not_empty}, 32'd0);
        pop = 1'b1;
        @(negedge clk); pop = 1'b0;
        @(negedge clk);
        chk(fill_count == 0, "R13 empty pop", {26'd0, fill_count}, 32'd0);
        send(32'h0000_0001);
        drain("R13 after empty pop");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule